// File: doc/BRIEF.md
# Remote Bus Master Sequencer

This block sits between a processor bus and a serial frame transceiver and lets the processor write to, or read from, any one of 128 remote slave units. The processor selects the block with an active-low chip select and issues one of three strobes. The write strobe sends a frame that carries a slave address and a data byte. The read strobe is overloaded. From idle it sends a read-request frame. After a good reply it places the received byte on the data bus. After a bad reply, or while a reply is still awaited, it abandons the transfer and returns to idle. The status strobe places a 3-bit progress code on the low data lines.

Each outgoing frame has a 7-bit address, a command bit, an 8-bit data field and an even-parity bit. The block hands these fields to the transceiver together with a one-cycle start pulse and waits for the transceiver's done pulse. A reply from the transceiver is accepted only when its address equals the requested slave and its parity is correct. The data bus is split into an output value and an enable. When the enable is low, the pad is meant to be high impedance.

Top module: `rbm_master`

## Requirements
- R1: While cs_n is high, data_oe is 0 and the strobes have no effect: the state and tx_start do not change.
- R2: In idle (code 111), a rising write strobe gives a one-cycle tx_start with tx_addr = addr_in, tx_data = data_in and tx_cmd = 1. The code becomes 001, and a tx_done pulse returns it to 111.
- R3: In idle, a rising read strobe gives a one-cycle tx_start with tx_addr = addr_in, tx_data = 0 and tx_cmd = 0. The code becomes 101, and a tx_done pulse moves it to 100 (waiting).
- R4: A reply on rx_valid in state 100 whose rx_addr equals the requested address and whose parity is correct moves the code to 010. A rising read strobe then drives the received byte on data_out with data_oe = 1, and the code returns to 111.
- R5: A reply with a different address or wrong parity moves the code from 100 to 110. A rising read strobe then returns the code to 111.
- R6: A rising read strobe in state 100 returns the code to 111. A reply that arrives in the same cycle is discarded.
- R7: With cs_n low and st_stb high, data_oe = 1 and data_out = {5'b00000, code}. The status strobe takes priority over a read strobe that is high at the same time.
- R8: The code is always one of 111, 001, 101, 100, 010 or 110. The codes 000 and 011 never appear.
- R9: Read and write strobes have no effect while a frame is being sent (codes 001 and 101).
- R10: After reset the code is 111, tx_start is 0 and data_oe is 0.
- R11: A strobe acts only on its rising edge, so a strobe held high acts once. If write and read rise together in idle, the write is taken.
- R12: The parity bit is chosen so that the total number of ones in {address, command, data, parity} is even. This applies to tx_par and to the check of rx_par.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select gating all strobes and the bus drive |
| rd_stb | input | 1 | Read strobe (start read, fetch data, or abort) |
| wr_stb | input | 1 | Write strobe |
| st_stb | input | 1 | Status strobe |
| addr_in | input | 7 | Slave address from the processor |
| data_in | input | 8 | Write data from the processor |
| data_out | output | 8 | Value driven onto the processor data bus |
| data_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| tx_start | output | 1 | One-cycle request to send a frame |
| tx_addr | output | 7 | Frame address field |
| tx_cmd | output | 1 | Frame command bit, 1 = write, 0 = read request |
| tx_data | output | 8 | Frame data field |
| tx_par | output | 1 | Frame even-parity bit |
| tx_done | input | 1 | Transceiver finished sending the frame |
| rx_valid | input | 1 | A reply frame has been received |
| rx_addr | input | 7 | Reply address field |
| rx_cmd | input | 1 | Reply command bit |
| rx_data | input | 8 | Reply data field |
| rx_par | input | 1 | Reply parity bit |

## Verification
Two events can fall in the same cycle while the block waits for a slave: the read strobe that abandons the transfer, and the arrival of the reply. The bench raises rd_stb and rx_valid, carrying a correctly formed reply, on the same clock edge. It then judges the result through a status read, which must show 111 and not 010. Reading the received byte back would only show a stale value. A second collision also needs a check. When the status strobe and a held read strobe are active together, the bus must carry the status code.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

  // State values double as the externally visible status code.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b111,
    ST_TXW   = 3'b001,
    ST_TXR   = 3'b101,
    ST_WAIT  = 3'b100,
    ST_VALID = 3'b010,
    ST_BAD   = 3'b110
  } rbm_state_e;

  localparam int unsigned CODE_W = 3;

  // Even parity over a zero-padded frame body.
  function automatic logic frame_parity(input logic [63:0] body);
    return ^body;
  endfunction

endpackage

// File: rtl/rbm_strobe_gate.sv
module rbm_strobe_gate #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic [N-1:0] stb,
  output logic [N-1:0] act,
  output logic [N-1:0] rise
);
  logic [N-1:0] act_q;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign act[i]  = stb[i] & ~cs_n;
    assign rise[i] = act[i] & ~act_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q[i] <= 1'b0;
      else        act_q[i] <= act[i];
    end
  end
endmodule

// File: rtl/rbm_reply_check.sv
module rbm_reply_check
  import rbm_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] rx_addr,
  input  logic          rx_cmd,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_par,
  output logic          addr_ok,
  output logic          par_ok,
  output logic          reply_ok
);
  assign addr_ok  = (rx_addr == req_addr);
  assign par_ok   = (rx_par == frame_parity(64'({rx_addr, rx_cmd, rx_data})));
  assign reply_ok = addr_ok & par_ok;
endmodule

// File: rtl/rbm_ctrl.sv
module rbm_ctrl
  import rbm_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rise,
  input  logic          rd_rise,
  input  logic          tx_done,
  input  logic          rx_valid,
  input  logic          reply_ok,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] rx_data,
  output rbm_state_e    state,
  output logic          tx_start,
  output logic [AW-1:0] tx_addr,
  output logic          tx_cmd,
  output logic [DW-1:0] tx_data,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tx_start <= 1'b0;
      tx_addr  <= '0;
      tx_cmd   <= 1'b0;
      tx_data  <= '0;
      rd_data  <= '0;
    end else begin
      tx_start <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (wr_rise) begin
            state    <= ST_TXW;
            tx_start <= 1'b1;
            tx_addr  <= addr_in;
            tx_cmd   <= 1'b1;
            tx_data  <= data_in;
          end else if (rd_rise) begin
            state    <= ST_TXR;
            tx_start <= 1'b1;
            tx_addr  <= addr_in;
            tx_cmd   <= 1'b0;
            tx_data  <= '0;
          end
        end
        ST_TXW: if (tx_done) state <= ST_IDLE;
        ST_TXR: if (tx_done) state <= ST_WAIT;
        ST_WAIT: begin
          if (rd_rise) state <= ST_IDLE;
          else if (rx_valid) begin
            if (reply_ok) begin
              state   <= ST_VALID;
              rd_data <= rx_data;
            end else begin
              state <= ST_BAD;
            end
          end
        end
        ST_VALID, ST_BAD: if (rd_rise) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rbm_master.sv
module rbm_master
  import rbm_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic          st_stb,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          tx_start,
  output logic [AW-1:0] tx_addr,
  output logic          tx_cmd,
  output logic [DW-1:0] tx_data,
  output logic          tx_par,
  input  logic          tx_done,
  input  logic          rx_valid,
  input  logic [AW-1:0] rx_addr,
  input  logic          rx_cmd,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_par
);
  localparam int unsigned PAD_W = DW - CODE_W;

  logic [2:0]  act, rise;
  logic        rd_act, st_act, rd_rise, wr_rise;
  logic        addr_ok, par_ok, reply_ok;
  rbm_state_e  state;
  logic [CODE_W-1:0] state_code;
  logic [DW-1:0]     rd_data;

  rbm_strobe_gate #(.N(3)) u_gate (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .stb({st_stb, wr_stb, rd_stb}), .act(act), .rise(rise)
  );

  assign rd_act  = act[0];
  assign st_act  = act[2];
  assign rd_rise = rise[0];
  assign wr_rise = rise[1];

  rbm_reply_check #(.AW(AW), .DW(DW)) u_check (
    .req_addr(tx_addr), .rx_addr(rx_addr), .rx_cmd(rx_cmd),
    .rx_data(rx_data), .rx_par(rx_par),
    .addr_ok(addr_ok), .par_ok(par_ok), .reply_ok(reply_ok)
  );

  rbm_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise), .rd_rise(rd_rise),
    .tx_done(tx_done), .rx_valid(rx_valid), .reply_ok(reply_ok),
    .addr_in(addr_in), .data_in(data_in), .rx_data(rx_data),
    .state(state), .tx_start(tx_start), .tx_addr(tx_addr),
    .tx_cmd(tx_cmd), .tx_data(tx_data), .rd_data(rd_data)
  );

  assign state_code = state;
  assign tx_par     = frame_parity(64'({tx_addr, tx_cmd, tx_data}));

  // Status drive wins over read drive.
  assign data_oe = rd_act | st_act;
  always_comb begin
    if (st_act)      data_out = {{PAD_W{1'b0}}, state_code};
    else if (rd_act) data_out = rd_data;
    else             data_out = '0;
  end
endmodule

// File: rtl/rbm_master_chk.sv
module rbm_master_chk #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          st_stb,
  input logic [DW-1:0] data_out,
  input logic          data_oe,
  input logic          tx_start,
  input logic [AW-1:0] tx_addr,
  input logic          tx_cmd,
  input logic [DW-1:0] tx_data,
  input logic          tx_par,
  input logic          rx_valid,
  input logic          rd_rise,
  input logic          reply_ok,
  input logic [2:0]    state_code
);
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !data_oe); // R1
  AST_DESELECT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && $past(state_code) == 3'b111) |-> (state_code == 3'b111 && !tx_start)); // R1
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(state_code) == 3'b111); // R2
  AST_CMD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_cmd == (state_code == 3'b001))); // R3
  AST_EVEN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !($countones({tx_addr, tx_cmd, tx_data, tx_par}) & 1)); // R12
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 3'b000 && state_code != 3'b011)); // R8
  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b100 && rd_rise) |=> state_code == 3'b111); // R6
  AST_BAD_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b100 && rx_valid && !rd_rise && !reply_ok) |=> state_code == 3'b110); // R5
  AST_GOOD_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b100 && rx_valid && !rd_rise && reply_ok) |=> state_code == 3'b010); // R4
  AST_STATUS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && st_stb) |-> (data_oe && data_out[DW-1:3] == '0)); // R7
endmodule

bind rbm_master rbm_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .st_stb(st_stb),
  .data_out(data_out), .data_oe(data_oe), .tx_start(tx_start),
  .tx_addr(tx_addr), .tx_cmd(tx_cmd), .tx_data(tx_data), .tx_par(tx_par),
  .rx_valid(rx_valid), .rd_rise(rd_rise), .reply_ok(reply_ok),
  .state_code(state_code)
);

// File: tb/rbm_master_test.sv
`timescale 1ns/1ps
module rbm_master_test;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_stb = 0, wr_stb = 0, st_stb = 0;
  logic [6:0] addr_in = 0, tx_addr, rx_addr = 0;
  logic [7:0] data_in = 0, data_out, tx_data, rx_data = 0;
  logic data_oe, tx_start, tx_cmd, tx_par, tx_done = 0, rx_valid = 0, rx_cmd = 0, rx_par = 0;
  int total = 0, bad = 0;
  logic [2:0] code;

  always #4 clk = ~clk;

  rbm_master uut (.*);

  // {op(1=write), addr[6:0], data[7:0], err(0 ok,1 addr,2 parity), code after reply}
  localparam logic [20:0] VEC [6] = '{
    {1'b1, 7'h15, 8'hA7, 2'd0, 3'b111},
    {1'b0, 7'h2A, 8'h3C, 2'd0, 3'b010},
    {1'b0, 7'h7F, 8'hFF, 2'd1, 3'b110},
    {1'b0, 7'h00, 8'h00, 2'd2, 3'b110},
    {1'b1, 7'h7F, 8'h00, 2'd0, 3'b111},
    {1'b0, 7'h41, 8'h81, 2'd0, 3'b010}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step; @(negedge clk); endtask

  function automatic logic even_par(input logic [6:0] a, input logic c, input logic [7:0] d);
    return logic'($countones({a, c, d}) % 2);
  endfunction

  task automatic read_status(output logic [2:0] c);
    st_stb = 1; #1;
    chk("R7 oe", data_oe, 1);
    chk("R7 upper", data_out[7:3], 0);
    c = data_out[2:0];
    st_stb = 0; #1;
  endtask

  task automatic pulse_done; tx_done = 1; step; tx_done = 0; endtask

  task automatic send_reply(input logic [6:0] a, input logic [7:0] d, input logic perr);
    rx_addr = a; rx_cmd = 0; rx_data = d; rx_par = even_par(a, 1'b0, d) ^ perr;
    rx_valid = 1;
  endtask

  initial begin
    #(8 * 150000);
    chk("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step; step;
    // R10 reset state
    chk("R10 tx_start", tx_start, 0);
    chk("R10 oe", data_oe, 0);
    rst_n = 1; step;
    cs_n = 0; read_status(code); chk("R10 code", code, 3'b111);

    // R1: deselected strobes ignored
    cs_n = 1; wr_stb = 1; rd_stb = 1; st_stb = 1; #1;
    chk("R1 oe", data_oe, 0);
    step; chk("R1 tx_start", tx_start, 0);
    wr_stb = 0; rd_stb = 0; st_stb = 0; step;
    cs_n = 0; read_status(code); chk("R1 code", code, 3'b111);

    // vector table (R2..R5, R12)
    for (int i = 0; i < 6; i++) begin
      logic op; logic [6:0] a; logic [7:0] d; logic [1:0] e; logic [2:0] ex;
      {op, a, d, e, ex} = VEC[i];
      addr_in = a; data_in = d;
      if (op) wr_stb = 1; else rd_stb = 1;
      step;
      chk("R2/R3 start", tx_start, 1);
      chk("R2/R3 addr", tx_addr, a);
      chk("R2/R3 cmd", tx_cmd, op);
      chk("R2/R3 data", tx_data, op ? d : 8'h00);
      chk("R12 parity", tx_par, even_par(a, op, op ? d : 8'h00));
      wr_stb = 0; rd_stb = 0; step;
      chk("R2 one-cycle start", tx_start, 0);
      read_status(code); chk("R2/R3 sending code", code, op ? 3'b001 : 3'b101);
      pulse_done;
      if (op) begin
        read_status(code); chk("R2 back idle", code, 3'b111);
      end else begin
        read_status(code); chk("R3 waiting", code, 3'b100);
        send_reply(e == 1 ? a ^ 7'h01 : a, d ^ 8'h5A, e == 2);
        step; rx_valid = 0;
        read_status(code); chk("R4/R5 reply code", code, ex);
        rd_stb = 1; #1;
        if (ex == 3'b010) begin
          chk("R4 data out", data_out, d ^ 8'h5A);
          chk("R4 oe", data_oe, 1);
        end
        step; rd_stb = 0; step;
        read_status(code); chk("R4/R5 idle after read", code, 3'b111);
      end
    end

    // R11: simultaneous rise, write wins; held strobe acts once
    addr_in = 7'h33; data_in = 8'h0F;
    wr_stb = 1; rd_stb = 1; step;
    chk("R11 start", tx_start, 1);
    chk("R11 write wins", tx_cmd, 1);
    step; chk("R11 no repeat", tx_start, 0);
    pulse_done; step;
    chk("R11 held no restart", tx_start, 0);
    // R7: status beats held read
    read_status(code); chk("R7 status over read", code, 3'b111);
    wr_stb = 0; rd_stb = 0; step;

    // R9: strobes ignored while sending a read request
    addr_in = 7'h12; rd_stb = 1; step; rd_stb = 0; step;
    wr_stb = 1; step; chk("R9 no start", tx_start, 0);
    wr_stb = 0; rd_stb = 1; step; rd_stb = 0; step;
    read_status(code); chk("R9 still sending", code, 3'b101);
    pulse_done;
    read_status(code); chk("R9 waiting", code, 3'b100);

    // R6: abort and good reply in the same cycle
    send_reply(7'h12, 8'hC3, 1'b0); rd_stb = 1; step;
    rx_valid = 0; rd_stb = 0; step;
    read_status(code); chk("R6 abort wins", code, 3'b111);
    chk("R6 no start", tx_start, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule